// File: doc/BRIEF.md
# Accumulator Datapath with Flagged ALU

This block is the arithmetic core of a small accumulator machine. It holds an accumulator register A, one general-purpose register B and three status flags (zero, signed overflow, carry). A packed 11-bit command word, applied together with an execute-enable strobe, tells it what to do in one clock cycle. The command word chooses the second ALU operand, the ALU operation, a flag to clear, and a new value for B.

The second operand comes from memory read data, an immediate operand, register B or the constant 1. The constant 1 lets increment and decrement reuse the add and subtract paths. Add, subtract and negate go through a ripple chain of full adders. Rotates move bits through the carry flag.

The block has no stream interface. A command is accepted on every rising edge where `exec_en` is high, and it never stalls, so there is no back-pressure. Results show on the outputs one cycle after the accepting edge. Instruction decode, the program counter and the memories are outside the block and drive its inputs.

Top module: `acc_datapath`

## Requirements
- R1: The command word is laid out as bits [10:9] B load select, [8:6] flag clear, [5:2] ALU operation, [1:0] second-operand select. Every field acts independently in the same cycle.
- R2: The second operand is chosen by the select field: 00 memory read data, 01 immediate, 10 register B, 11 the constant 1.
- R3: Operation 0000 writes A+Y to A. C is the unsigned carry out, OV is signed overflow (82+91 gives 0xAD with OV=1), and Z is set when the result is 0.
- R4: Operation 0001 writes A−Y to A. C is set on unsigned borrow (A<Y), OV is signed overflow, and Z is set when the result is 0.
- R5: Operations 0011 (load Y), 0100 (AND), 0101 (OR), 0110 (XOR), 1100 (NOT A) and 1101 (clear A) update A and Z only. C and OV keep their values.
- R6: Operation 1001 writes 0−A to A. C is set when A was nonzero, OV is set when A was 0x80, and Z follows the result.
- R7: Operation 0111 shifts right and keeps bit 7. Operation 1000 keeps bit 7, moves bits 5..0 up one place and fills bit 0 with 0. Operation 1010 shifts toward the MSB with a 0 fill. Operation 1011 shifts toward the LSB with a 0 fill. All four update Z only.
- R8: Operation 1110 rotates right through carry: the old C goes into bit 7 and bit 0 goes into C. Operation 1111 rotates left through carry: the old C goes into bit 0 and bit 7 goes into C. Z is updated and OV is kept.
- R9: Operation 0010 leaves A and all flags unchanged.
- R10: Flag-clear code 001 clears Z, 011 clears OV and 100 clears C. Any other code clears nothing. A clear wins over a flag update in the same cycle.
- R11: The B load field 01 loads the immediate, 11 loads memory read data, and 00 or 10 keep B.
- R12: While `exec_en` is low, A, B and all flags hold, whatever the command word is.
- R13: A synchronous reset clears A, B and all three flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Accept the command word on this edge |
| cmd | input | 11 | Packed command word |
| imm | input | 8 | Immediate operand |
| mem_rdata | input | 8 | Memory read data |
| acc_o | output | 8 | Accumulator A |
| b_o | output | 8 | Register B |
| z_o | output | 1 | Zero flag |
| ov_o | output | 1 | Signed overflow flag |
| c_o | output | 1 | Carry / borrow flag |

## Verification
The assertions check the following on every cycle:
- holding while `exec_en` is low;
- the effect of each flag-clear code and its priority over updates;
- C and OV staying put across logic, load and clear operations;
- the immediate load into B;
- the bit movement of a left rotate through carry;
- the idle operation;
- reset.

The arithmetic itself can only be shown by the directed scenarios against a reference model. This covers carry, borrow and overflow at boundary values such as 0xFF+1, 82+91, 0x80−1 and negation of 0 and 0x80, as well as the exact bit patterns of each shift and the round trip of nine rotations.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;
  localparam int CMD_W = 11;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0, OP_SUB = 4'h1, OP_IDLE = 4'h2, OP_LOAD = 4'h3,
    OP_AND  = 4'h4, OP_OR  = 4'h5, OP_XOR  = 4'h6, OP_ASR  = 4'h7,
    OP_ASL  = 4'h8, OP_NEG = 4'h9, OP_SHL  = 4'hA, OP_SHR  = 4'hB,
    OP_NOT  = 4'hC, OP_CLR = 4'hD, OP_RRC  = 4'hE, OP_RLC  = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_MEM = 2'b00, SRC_IMM = 2'b01, SRC_REGB = 2'b10, SRC_ONE = 2'b11
  } opnd_sel_e;

  localparam logic [1:0] BLD_IMM = 2'b01;
  localparam logic [1:0] BLD_MEM = 2'b11;

  localparam logic [2:0] FCLR_NONE = 3'b000;
  localparam logic [2:0] FCLR_Z    = 3'b001;
  localparam logic [2:0] FCLR_OV   = 3'b011;
  localparam logic [2:0] FCLR_C    = 3'b100;

  typedef struct packed {
    logic [1:0] bld;
    logic [2:0] fclr;
    alu_op_e    op;
    opnd_sel_e  src;
  } cmd_t;
endpackage

// File: rtl/acc_dp_opsel.sv
module acc_dp_opsel
  import acc_dp_pkg::*;
#(
  parameter int W = 8
) (
  input  opnd_sel_e      sel,
  input  logic [W-1:0]   mem_rdata,
  input  logic [W-1:0]   imm,
  input  logic [W-1:0]   breg,
  output logic [W-1:0]   y
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    unique case (sel)
      SRC_MEM:  y = mem_rdata;
      SRC_IMM:  y = imm;
      SRC_REGB: y = breg;
      SRC_ONE:  y = ONE;
    endcase
  end
endmodule

// File: rtl/acc_dp_ripple.sv
module acc_dp_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         c_msb
);
  logic [W:0] cy;
  assign cy[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]   = a[i] ^ b[i] ^ cy[i];
    assign cy[i+1]  = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
  end

  assign cout  = cy[W];
  assign c_msb = cy[W-1];
endmodule

// File: rtl/acc_dp_alu.sv
module acc_dp_alu
  import acc_dp_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] y,
  input  logic         c_in,
  output logic [W-1:0] res,
  output logic         z_new,
  output logic         c_new,
  output logic         ov_new,
  output logic         wr_a,
  output logic         wr_z,
  output logic         wr_c,
  output logic         wr_ov
);
  logic [W-1:0] add_a, add_b, sum;
  logic         add_ci, cout, c_msb;

  always_comb begin
    add_a  = a;
    add_b  = y;
    add_ci = 1'b0;
    if (op == OP_SUB) begin
      add_b  = ~y;
      add_ci = 1'b1;
    end else if (op == OP_NEG) begin
      add_a  = '0;
      add_b  = ~a;
      add_ci = 1'b1;
    end
  end

  acc_dp_ripple #(.W(W)) u_add (
    .a(add_a), .b(add_b), .cin(add_ci),
    .sum(sum), .cout(cout), .c_msb(c_msb)
  );

  always_comb begin
    res    = a;
    c_new  = c_in;
    ov_new = cout ^ c_msb;
    wr_a   = 1'b1;
    wr_z   = 1'b1;
    wr_c   = 1'b0;
    wr_ov  = 1'b0;
    unique case (op)
      OP_ADD:  begin res = sum; c_new = cout;  wr_c = 1'b1; wr_ov = 1'b1; end
      OP_SUB,
      OP_NEG:  begin res = sum; c_new = ~cout; wr_c = 1'b1; wr_ov = 1'b1; end
      OP_IDLE: begin wr_a = 1'b0; wr_z = 1'b0; end
      OP_LOAD: res = y;
      OP_AND:  res = a & y;
      OP_OR:   res = a | y;
      OP_XOR:  res = a ^ y;
      OP_ASR:  res = {a[W-1], a[W-1:1]};
      OP_ASL:  res = {a[W-1], a[W-3:0], 1'b0};
      OP_SHL:  res = {a[W-2:0], 1'b0};
      OP_SHR:  res = {1'b0, a[W-1:1]};
      OP_NOT:  res = ~a;
      OP_CLR:  res = '0;
      OP_RRC:  begin res = {c_in, a[W-1:1]}; c_new = a[0];   wr_c = 1'b1; end
      OP_RLC:  begin res = {a[W-2:0], c_in}; c_new = a[W-1]; wr_c = 1'b1; end
    endcase
  end

  assign z_new = (res == '0);
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_dp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             exec_en,
  input  logic [CMD_W-1:0] cmd,
  input  logic [W-1:0]     imm,
  input  logic [W-1:0]     mem_rdata,
  output logic [W-1:0]     acc_o,
  output logic [W-1:0]     b_o,
  output logic             z_o,
  output logic             ov_o,
  output logic             c_o
);
  cmd_t         c;
  logic [W-1:0] y, res;
  logic         z_new, c_new, ov_new, wr_a, wr_z, wr_c, wr_ov;
  logic         clr_z, clr_ov, clr_c;

  assign c = cmd_t'(cmd);

  acc_dp_opsel #(.W(W)) u_sel (
    .sel(c.src), .mem_rdata(mem_rdata), .imm(imm), .breg(b_o), .y(y)
  );

  acc_dp_alu #(.W(W)) u_alu (
    .op(c.op), .a(acc_o), .y(y), .c_in(c_o),
    .res(res), .z_new(z_new), .c_new(c_new), .ov_new(ov_new),
    .wr_a(wr_a), .wr_z(wr_z), .wr_c(wr_c), .wr_ov(wr_ov)
  );

  assign clr_z  = (c.fclr == FCLR_Z);
  assign clr_ov = (c.fclr == FCLR_OV);
  assign clr_c  = (c.fclr == FCLR_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o <= '0;
      b_o   <= '0;
      z_o   <= 1'b0;
      ov_o  <= 1'b0;
      c_o   <= 1'b0;
    end else if (exec_en) begin
      if (wr_a) acc_o <= res;
      if (c.bld == BLD_IMM)      b_o <= imm;
      else if (c.bld == BLD_MEM) b_o <= mem_rdata;
      if (clr_z)       z_o  <= 1'b0;
      else if (wr_z)   z_o  <= z_new;
      if (clr_ov)      ov_o <= 1'b0;
      else if (wr_ov)  ov_o <= ov_new;
      if (clr_c)       c_o  <= 1'b0;
      else if (wr_c)   c_o  <= c_new;
    end
  end
endmodule

// File: rtl/acc_datapath_chk.sv
module acc_datapath_chk
  import acc_dp_pkg::*;
#(
  parameter int W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             exec_en,
  input logic [CMD_W-1:0] cmd,
  input logic [W-1:0]     imm,
  input logic [W-1:0]     mem_rdata,
  input logic [W-1:0]     acc_o,
  input logic [W-1:0]     b_o,
  input logic             z_o,
  input logic             ov_o,
  input logic             c_o
);
  cmd_t cc;
  assign cc = cmd_t'(cmd);

  logic keeps_cv;
  assign keeps_cv = (cc.op == OP_AND) || (cc.op == OP_OR) || (cc.op == OP_XOR) ||
                    (cc.op == OP_NOT) || (cc.op == OP_CLR) || (cc.op == OP_LOAD);

  a_r13_reset: assert property (@(posedge clk)
    rst |=> (acc_o == '0 && b_o == '0 && !z_o && !ov_o && !c_o));

  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> ($stable(acc_o) && $stable(b_o) && $stable(z_o) && $stable(ov_o) && $stable(c_o)));

  a_r10_clr_z: assert property (@(posedge clk) disable iff (rst)
    (exec_en && cc.fclr == FCLR_Z) |=> !z_o);

  a_r10_clr_ov: assert property (@(posedge clk) disable iff (rst)
    (exec_en && cc.fclr == FCLR_OV) |=> !ov_o);

  a_r10_clr_c: assert property (@(posedge clk) disable iff (rst)
    (exec_en && cc.fclr == FCLR_C) |=> !c_o);

  a_r5_keep_c_ov: assert property (@(posedge clk) disable iff (rst)
    (exec_en && keeps_cv && cc.fclr == FCLR_NONE) |=> ($stable(c_o) && $stable(ov_o)));

  a_r5_clear_acc: assert property (@(posedge clk) disable iff (rst)
    (exec_en && cc.op == OP_CLR) |=> (acc_o == '0));

  a_r11_b_imm: assert property (@(posedge clk) disable iff (rst)
    (exec_en && cc.bld == BLD_IMM) |=> (b_o == $past(imm)));

  a_r11_b_mem: assert property (@(posedge clk) disable iff (rst)
    (exec_en && cc.bld == BLD_MEM) |=> (b_o == $past(mem_rdata)));

  a_r8_rlc: assert property (@(posedge clk) disable iff (rst)
    (exec_en && cc.op == OP_RLC && cc.fclr != FCLR_C) |=>
      (c_o == $past(acc_o[W-1]) && acc_o[0] == $past(c_o)));

  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    (exec_en && cc.op == OP_IDLE) |=> $stable(acc_o));
endmodule

bind acc_datapath acc_datapath_chk #(.W(W)) u_chk (.*);

// File: tb/sim_acc_datapath.sv
module sim_acc_datapath;
  logic        clk = 1'b0;
  logic        rst, exec_en;
  logic [10:0] cmd;
  logic [7:0]  imm, mem_rdata;
  logic [7:0]  acc_o, b_o;
  logic        z_o, ov_o, c_o;

  int checks = 0;
  int failures = 0;

  logic [7:0] m_a, m_b;
  logic       m_z, m_ov, m_c;

  always #5 clk = ~clk;

  acc_datapath u0 (
    .clk(clk), .rst(rst), .exec_en(exec_en), .cmd(cmd), .imm(imm),
    .mem_rdata(mem_rdata), .acc_o(acc_o), .b_o(b_o),
    .z_o(z_o), .ov_o(ov_o), .c_o(c_o)
  );

  task automatic check(input string tag);
    checks++;
    if (acc_o !== m_a || b_o !== m_b || z_o !== m_z || ov_o !== m_ov || c_o !== m_c) begin
      failures++;
      $display("FAIL %s: actual A=%h B=%h Z=%b OV=%b C=%b expected A=%h B=%h Z=%b OV=%b C=%b",
               tag, acc_o, b_o, z_o, ov_o, c_o, m_a, m_b, m_z, m_ov, m_c);
    end
  endtask

  task automatic run(input logic [1:0] bs, input logic [2:0] fc, input logic [3:0] op,
                     input logic [1:0] src, input logic [7:0] iv, input logic [7:0] mv,
                     input logic en);
    logic [7:0] y, r;
    logic [8:0] s;
    logic nz, nov, nc, wa, wz;
    y  = (src == 2'd0) ? mv : (src == 2'd1) ? iv : (src == 2'd2) ? m_b : 8'd1;
    r  = m_a; nz = m_z; nov = m_ov; nc = m_c; wa = 1'b1; wz = 1'b1;
    case (op)
      4'h0: begin s = {1'b0, m_a} + {1'b0, y}; r = s[7:0]; nc = s[8];
                  nov = (m_a[7] == y[7]) && (r[7] != m_a[7]); end
      4'h1: begin r = m_a - y; nc = (m_a < y);
                  nov = (m_a[7] != y[7]) && (r[7] != m_a[7]); end
      4'h2: begin wa = 1'b0; wz = 1'b0; end
      4'h3: r = y;
      4'h4: r = m_a & y;
      4'h5: r = m_a | y;
      4'h6: r = m_a ^ y;
      4'h7: r = {m_a[7], m_a[7:1]};
      4'h8: r = {m_a[7], m_a[5:0], 1'b0};
      4'h9: begin r = 8'd0 - m_a; nc = (m_a != 8'd0); nov = (m_a == 8'h80); end
      4'hA: r = {m_a[6:0], 1'b0};
      4'hB: r = {1'b0, m_a[7:1]};
      4'hC: r = ~m_a;
      4'hD: r = 8'd0;
      4'hE: begin r = {m_c, m_a[7:1]}; nc = m_a[0]; end
      4'hF: begin r = {m_a[6:0], m_c}; nc = m_a[7]; end
      default: ;
    endcase
    if (wz) nz = (r == 8'd0);
    if (fc == 3'b001) nz = 1'b0;
    if (fc == 3'b011) nov = 1'b0;
    if (fc == 3'b100) nc = 1'b0;
    @(negedge clk);
    cmd = {bs, fc, op, src}; imm = iv; mem_rdata = mv; exec_en = en;
    @(negedge clk);
    exec_en = 1'b0;
    if (en) begin
      if (wa) m_a = r;
      m_z = nz; m_ov = nov; m_c = nc;
      if (bs == 2'b01) m_b = iv;
      else if (bs == 2'b11) m_b = mv;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_a = 8'd0; m_b = 8'd0; m_z = 1'b0; m_ov = 1'b0; m_c = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R13 reset state");
  endtask

  task automatic t_add();
    run(2'b01, 3'b000, 4'h2, 2'd0, 8'd91, 8'h00, 1'b1); check("R11 load B from imm");
    run(2'b00, 3'b000, 4'h3, 2'd1, 8'd82, 8'h00, 1'b1); check("R5 load A from imm");
    run(2'b00, 3'b000, 4'h0, 2'd2, 8'h00, 8'h00, 1'b1); check("R3 82+91 signed overflow via B");
    run(2'b00, 3'b000, 4'h3, 2'd0, 8'h00, 8'hFF, 1'b1); check("R2 load A from memory");
    run(2'b00, 3'b000, 4'h0, 2'd3, 8'h00, 8'h00, 1'b1); check("R3 0xFF+1 carry and zero");
    run(2'b11, 3'b000, 4'h0, 2'd0, 8'h00, 8'h40, 1'b1); check("R11 load B from memory with add");
  endtask

  task automatic t_sub();
    run(2'b00, 3'b000, 4'h3, 2'd1, 8'd5, 8'h00, 1'b1);  check("R5 load 5");
    run(2'b00, 3'b000, 4'h1, 2'd1, 8'd7, 8'h00, 1'b1);  check("R4 5-7 borrow");
    run(2'b00, 3'b000, 4'h3, 2'd1, 8'h80, 8'h00, 1'b1); check("R5 load 0x80");
    run(2'b00, 3'b000, 4'h1, 2'd0, 8'h00, 8'h01, 1'b1); check("R4 0x80-1 overflow");
    run(2'b00, 3'b000, 4'h1, 2'd3, 8'h00, 8'h00, 1'b1); check("R2 decrement via constant 1");
    run(2'b00, 3'b000, 4'h1, 2'd1, 8'h7E, 8'h00, 1'b1); check("R4 equal operands give zero");
  endtask

  task automatic t_logic();
    run(2'b01, 3'b000, 4'h3, 2'd1, 8'hF0, 8'h3C, 1'b1); check("R5 load with B update");
    run(2'b00, 3'b000, 4'h0, 2'd1, 8'h20, 8'h00, 1'b1); check("R3 add sets carry");
    run(2'b00, 3'b000, 4'h4, 2'd0, 8'h00, 8'h3C, 1'b1); check("R5 AND keeps C");
    run(2'b00, 3'b000, 4'h5, 2'd2, 8'h00, 8'h00, 1'b1); check("R5 OR with B");
    run(2'b00, 3'b000, 4'h6, 2'd1, 8'hFF, 8'h00, 1'b1); check("R5 XOR");
    run(2'b00, 3'b000, 4'hC, 2'd0, 8'h00, 8'h00, 1'b1); check("R5 NOT");
    run(2'b00, 3'b000, 4'hD, 2'd0, 8'h00, 8'h00, 1'b1); check("R5 clear A sets Z");
  endtask

  task automatic t_neg();
    run(2'b00, 3'b000, 4'h3, 2'd1, 8'h80, 8'h00, 1'b1); check("R5 load 0x80");
    run(2'b00, 3'b000, 4'h9, 2'd0, 8'h00, 8'h00, 1'b1); check("R6 negate 0x80");
    run(2'b00, 3'b000, 4'h3, 2'd1, 8'h00, 8'h00, 1'b1); check("R5 load 0");
    run(2'b00, 3'b000, 4'h9, 2'd0, 8'h00, 8'h00, 1'b1); check("R6 negate 0");
    run(2'b00, 3'b000, 4'h3, 2'd1, 8'h05, 8'h00, 1'b1); check("R5 load 5");
    run(2'b00, 3'b000, 4'h9, 2'd0, 8'h00, 8'h00, 1'b1); check("R6 negate 5");
  endtask

  task automatic t_shift();
    logic [3:0] ops [4] = '{4'h7, 4'h8, 4'hA, 4'hB};
    foreach (ops[k]) begin
      run(2'b00, 3'b000, 4'h3, 2'd1, 8'hB5, 8'h00, 1'b1);
      run(2'b00, 3'b000, ops[k], 2'd0, 8'h00, 8'h00, 1'b1); check("R7 shift of 0xB5");
    end
    run(2'b00, 3'b000, 4'h3, 2'd1, 8'h01, 8'h00, 1'b1);
    run(2'b00, 3'b000, 4'hB, 2'd0, 8'h00, 8'h00, 1'b1); check("R7 right shift to zero");
  endtask

  task automatic t_rotate();
    run(2'b00, 3'b000, 4'h3, 2'd1, 8'hFF, 8'h00, 1'b1);
    run(2'b00, 3'b000, 4'h0, 2'd3, 8'h00, 8'h00, 1'b1);
    run(2'b00, 3'b000, 4'h3, 2'd1, 8'h5A, 8'h00, 1'b1); check("R8 setup C=1");
    for (int i = 0; i < 9; i++) begin
      run(2'b00, 3'b000, 4'hE, 2'd0, 8'h00, 8'h00, 1'b1); check("R8 rotate right through carry");
    end
    for (int i = 0; i < 9; i++) begin
      run(2'b00, 3'b000, 4'hF, 2'd0, 8'h00, 8'h00, 1'b1); check("R8 rotate left through carry");
    end
  endtask

  task automatic t_idle();
    run(2'b00, 3'b000, 4'h3, 2'd1, 8'h81, 8'h00, 1'b1);
    run(2'b00, 3'b000, 4'h2, 2'd1, 8'h00, 8'h00, 1'b1); check("R9 idle keeps A and flags");
  endtask

  task automatic t_clear();
    run(2'b00, 3'b000, 4'h3, 2'd1, 8'h80, 8'h00, 1'b1);
    run(2'b00, 3'b000, 4'h1, 2'd3, 8'h00, 8'h00, 1'b1); check("R4 setup OV");
    run(2'b00, 3'b011, 4'h2, 2'd0, 8'h00, 8'h00, 1'b1); check("R10 clear OV");
    run(2'b00, 3'b000, 4'h3, 2'd1, 8'hFF, 8'h00, 1'b1);
    run(2'b00, 3'b000, 4'h0, 2'd3, 8'h00, 8'h00, 1'b1); check("R10 setup Z and C");
    run(2'b00, 3'b010, 4'h2, 2'd0, 8'h00, 8'h00, 1'b1); check("R10 code 010 clears nothing");
    run(2'b00, 3'b100, 4'h2, 2'd0, 8'h00, 8'h00, 1'b1); check("R10 clear C");
    run(2'b00, 3'b001, 4'hD, 2'd0, 8'h00, 8'h00, 1'b1); check("R10 clear Z beats update");
    run(2'b00, 3'b000, 4'h3, 2'd1, 8'hFF, 8'h00, 1'b1);
    run(2'b00, 3'b100, 4'h0, 2'd3, 8'h00, 8'h00, 1'b1); check("R10 clear C beats carry");
  endtask

  task automatic t_fields();
    run(2'b01, 3'b100, 4'h0, 2'd1, 8'hC3, 8'h11, 1'b1); check("R1 all fields in one word");
    run(2'b11, 3'b001, 4'h6, 2'd0, 8'h22, 8'h77, 1'b1); check("R1 second field mix");
  endtask

  task automatic t_hold();
    run(2'b01, 3'b100, 4'h0, 2'd1, 8'hEE, 8'h00, 1'b0); check("R12 hold with exec_en low");
    run(2'b11, 3'b001, 4'hD, 2'd0, 8'h00, 8'h99, 1'b0); check("R12 hold clear cmd");
  endtask

  task automatic t_mid_reset();
    run(2'b01, 3'b000, 4'h3, 2'd1, 8'h5C, 8'h00, 1'b1);
    do_reset();
    check("R13 reset after activity");
  endtask

  initial begin
    rst = 1'b1; exec_en = 1'b0; cmd = '0; imm = '0; mem_rdata = '0;
    m_a = '0; m_b = '0; m_z = 1'b0; m_ov = 1'b0; m_c = 1'b0;
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_neg();
    t_shift();
    t_rotate();
    t_idle();
    t_clear();
    t_fields();
    t_hold();
    t_mid_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule